// File: doc/BRIEF.md
# Timer Channel with Selectable Counter Clear

A single timer channel built around a 16-bit up-counter. The counter advances on a count enable. That enable comes either from the peripheral clock divided by 1, 4, 16 or 64, or from a rising edge on one of four external clock pins. Four compare registers, named A to D, are checked against the counter on every active count enable. A 3-bit clear-select field chooses the event that returns the counter to zero: a match on one of the four registers, a synchronous clear request from a peer channel, or nothing at all.

Registers C and D each have a buffer-mode flag. While that flag is set, the register produces no compare match, so it can neither flag a match nor clear the counter. When the channel clears itself on its own compare match, it emits a one-cycle clear pulse. Peer channels use this pulse as their synchronous clear input.

A parameter builds a reduced variant. In that variant the top bit of the clear-select field reads as zero, so only register A, register B or the peer clear can be chosen. Control fields and register values are plain input ports.

Top module: `timer_channel`

## Requirements
- R1: While rst_ni is low and right after reset, cnt_o is 0 and clr_out_o is 0.
- R2: clk_sel_i codes 000, 001, 010 and 011 count the clock divided by 1, 4, 16 and 64. From a free-running prescaler that starts at zero on reset, the counter holds floor(E/N) after E clock edges.
- R3: clk_sel_i codes 100 to 111 select ext_clk_i bits 0 to 3. Each pin passes through two synchronizer flops, and each rising edge on the selected pin advances the counter exactly once. Edges on the other pins have no effect.
- R4: match_o bit k (A=0, B=1, C=2, D=3) is high in a cycle where the count enable is active and cnt_o equals that register's value.
- R5: clr_sel_i codes 001, 010, 101 and 110 clear on a match of A, B, C and D respectively. On the count enable where the match occurs, the counter goes to 0 instead of incrementing.
- R6: clr_sel_i codes 000 and 100 never clear the counter on an event. The counter keeps counting past every register value.
- R7: clr_sel_i codes 011 and 111 with sync_en_i=1 clear the counter at the clock edge where sync_clr_i is high, whatever the count enable. With sync_en_i=0, sync_clr_i has no effect.
- R8: With buf_c_i=1 (or buf_d_i=1), match_o bit 2 (or bit 3) stays 0. Selecting that register as the clear source then never clears the counter.
- R9: clr_out_o is high exactly in the cycles where the channel clears itself on its own compare match. It is never high for a synchronous clear.
- R10: With REDUCED=1, bit 2 of clr_sel_i is ignored. Code 101 acts as 001, 110 acts as 010, and 100 acts as 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_sel_i | input | 3 | Count clock select |
| clr_sel_i | input | 3 | Counter clear source select |
| sync_en_i | input | 1 | Enables peer synchronous clear |
| sync_clr_i | input | 1 | Synchronous clear request from a peer |
| buf_c_i | input | 1 | Register C in buffer mode |
| buf_d_i | input | 1 | Register D in buffer mode |
| gr_a_i | input | 16 | Compare register A |
| gr_b_i | input | 16 | Compare register B |
| gr_c_i | input | 16 | Compare register C |
| gr_d_i | input | 16 | Compare register D |
| ext_clk_i | input | 4 | External clock pins |
| cnt_o | output | 16 | Counter value |
| match_o | output | 4 | Compare match flags, D..A |
| clr_out_o | output | 1 | Clear pulse for peers |

## Verification
The assertions check the following on every cycle:
- the counter holds without an enable and steps by one with an enable;
- it reaches zero after an own-match clear or a synchronous clear;
- buffered registers never flag a match;
- the clear pulse never appears without a match;
- the synchronizer never reports two edges back to back.

Other behaviours can only be shown by the bench's scenarios, because they depend on how many edges arrive over time:
- the division ratios;
- that exactly one count follows each external pulse while the other pins are ignored;
- the period each clear code produces;
- how the reduced variant folds the codes.

// File: rtl/tck_pkg.sv
package tck_pkg;
  localparam int unsigned NUM_GR  = 4;
  localparam int unsigned NUM_DIV = 4;
  localparam int unsigned NUM_EXT = 4;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned GR_A = 0;
  localparam int unsigned GR_B = 1;
  localparam int unsigned GR_C = 2;
  localparam int unsigned GR_D = 3;
endpackage

// File: rtl/tck_prescale.sv
module tck_prescale #(
  parameter int unsigned NUM_DIV = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_DIV),
  localparam int unsigned P_W    = 2 * (NUM_DIV - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [P_W-1:0] p_q;
  logic [P_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_q <= '0;
    else         p_q <= p_q + 1'b1;
  end

  // ratio 4**sel: low 2*sel bits all ones
  always_comb begin
    for (int i = 0; i < P_W; i++) mask[i] = (i < 2 * int'(sel_i));
  end

  assign tick_o = ((p_q & mask) == mask);

  a_r2_div1_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> tick_o);
endmodule

// File: rtl/tck_ext_edge.sv
module tck_ext_edge #(
  parameter int unsigned N_PINS = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] rise_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-1:0], pin_i[g]};
    end
    assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];

    a_r3_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/tck_cmp_clr.sv
module tck_cmp_clr
  import tck_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic                          cnt_en_i,
  input  logic [NUM_GR-1:0][CNT_W-1:0]  gr_i,
  input  logic                          buf_c_i,
  input  logic                          buf_d_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic                          sync_en_i,
  input  logic                          sync_clr_i,
  output logic [NUM_GR-1:0]             match_o,
  output logic                          own_clr_o,
  output logic                          sync_hit_o
);
  logic [NUM_GR-1:0] gr_live;
  logic [1:0]        own_idx;
  logic              own_sel, sync_sel;

  always_comb begin
    gr_live       = '1;
    gr_live[GR_C] = ~buf_c_i;
    gr_live[GR_D] = ~buf_d_i;
  end

  for (genvar k = 0; k < NUM_GR; k++) begin : g_cmp
    assign match_o[k] = cnt_en_i & gr_live[k] & (cnt_i == gr_i[k]);
  end

  // 001/010 -> A/B, 101/110 -> C/D, x11 -> peer, x00 -> none
  assign own_idx    = {sel_i[2], sel_i[1]};
  assign own_sel    = sel_i[1] ^ sel_i[0];
  assign sync_sel   = sel_i[1] & sel_i[0];
  assign own_clr_o  = own_sel & match_o[own_idx];
  assign sync_hit_o = sync_sel & sync_en_i & sync_clr_i;

  a_r8_buf_c_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_c_i |-> !match_o[GR_C]);
  a_r8_buf_d_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_d_i |-> !match_o[GR_D]);
  a_r4_match_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|match_o) |-> cnt_en_i);
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import tck_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter bit          REDUCED = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   clk_sel_i,
  input  logic [SEL_W-1:0]   clr_sel_i,
  input  logic               sync_en_i,
  input  logic               sync_clr_i,
  input  logic               buf_c_i,
  input  logic               buf_d_i,
  input  logic [CNT_W-1:0]   gr_a_i,
  input  logic [CNT_W-1:0]   gr_b_i,
  input  logic [CNT_W-1:0]   gr_c_i,
  input  logic [CNT_W-1:0]   gr_d_i,
  input  logic [NUM_EXT-1:0] ext_clk_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [NUM_GR-1:0]  match_o,
  output logic               clr_out_o
);
  logic [CNT_W-1:0]              cnt_q;
  logic [NUM_GR-1:0][CNT_W-1:0]  gr;
  logic [SEL_W-1:0]              clr_sel_eff;
  logic [NUM_EXT-1:0]            ext_rise;
  logic                          pre_tick, cnt_en, own_clr, sync_hit;

  assign gr = {gr_d_i, gr_c_i, gr_b_i, gr_a_i};

  if (REDUCED) begin : g_reduced
    assign clr_sel_eff = {1'b0, clr_sel_i[1:0]};
  end else begin : g_full
    assign clr_sel_eff = clr_sel_i;
  end

  tck_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(clk_sel_i[1:0]), .tick_o(pre_tick)
  );

  tck_ext_edge #(.N_PINS(NUM_EXT), .STAGES(2)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ext_clk_i), .rise_o(ext_rise)
  );

  assign cnt_en = clk_sel_i[2] ? ext_rise[clk_sel_i[1:0]] : pre_tick;

  tck_cmp_clr #(.CNT_W(CNT_W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt_q), .cnt_en_i(cnt_en), .gr_i(gr),
    .buf_c_i(buf_c_i), .buf_d_i(buf_d_i), .sel_i(clr_sel_eff),
    .sync_en_i(sync_en_i), .sync_clr_i(sync_clr_i),
    .match_o(match_o), .own_clr_o(own_clr), .sync_hit_o(sync_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (sync_hit)          cnt_q <= '0;
    else if (cnt_en && own_clr) cnt_q <= '0;
    else if (cnt_en)            cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign clr_out_o = own_clr;

  a_r5_own_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_clr |=> (cnt_q == '0));
  a_r7_sync_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i && sync_clr_i && clr_sel_i[1:0] == 2'b11) |=> (cnt_q == '0));
  a_r2_hold_no_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en && !sync_hit) |=> $stable(cnt_q));
  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en && !own_clr && !sync_hit) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r9_pulse_has_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_out_o |-> (|match_o));
endmodule

// File: tb/tb_timer_channel.sv
`timescale 1ns/1ps
module tb_timer_channel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  clk_sel_i = '0, clr_sel_i = '0;
  logic        sync_en_i = 1'b0, sync_clr_i = 1'b0, buf_c_i = 1'b0, buf_d_i = 1'b0;
  logic [15:0] gr_a_i = 16'd2, gr_b_i = 16'd4, gr_c_i = 16'd6, gr_d_i = 16'd9;
  logic [3:0]  ext_clk_i = '0;
  logic [15:0] cnt_o, cnt_r;
  logic [3:0]  match_o, match_r;
  logic        clr_out_o, clr_out_r;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  timer_channel #(.REDUCED(1'b0)) dut (
    .clk_i, .rst_ni, .clk_sel_i, .clr_sel_i, .sync_en_i, .sync_clr_i, .buf_c_i,
    .buf_d_i, .gr_a_i, .gr_b_i, .gr_c_i, .gr_d_i, .ext_clk_i,
    .cnt_o(cnt_o), .match_o(match_o), .clr_out_o(clr_out_o));

  timer_channel #(.REDUCED(1'b1)) dut_r (
    .clk_i, .rst_ni, .clk_sel_i, .clr_sel_i, .sync_en_i, .sync_clr_i, .buf_c_i,
    .buf_d_i, .gr_a_i, .gr_b_i, .gr_c_i, .gr_d_i, .ext_clk_i,
    .cnt_o(cnt_r), .match_o(match_r), .clr_out_o(clr_out_r));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // match value that clears for a given code, -1 when none
  function automatic int clr_val(input int code, input bit red, input bit bc, input bit bd);
    int c;
    c = red ? (code & 3) : code;
    case (c)
      1: return int'(gr_a_i);
      2: return int'(gr_b_i);
      5: return bc ? -1 : int'(gr_c_i);
      6: return bd ? -1 : int'(gr_d_i);
      default: return -1;
    endcase
  endfunction

  task automatic sweep_clear(input bit bc, input bit bd);
    int m, mr, e_cnt, e_r, em;
    for (int code = 0; code < 8; code++) begin
      clr_sel_i = 3'(code); clk_sel_i = 3'd0; buf_c_i = bc; buf_d_i = bd;
      do_reset();
      m  = clr_val(code, 1'b0, bc, bd);
      mr = clr_val(code, 1'b1, bc, bd);
      for (int e = 1; e <= 30; e++) begin
        @(negedge clk_i);
        e_cnt = (m < 0) ? e : e % (m + 1);
        e_r   = (mr < 0) ? e : e % (mr + 1);
        check((m < 0) ? "R6 no-clear count" : "R5 clear period", int'(cnt_o), e_cnt);
        check("R10 reduced fold", int'(cnt_r), e_r);
        em = 0;
        if (e_cnt == int'(gr_a_i)) em |= 1;
        if (e_cnt == int'(gr_b_i)) em |= 2;
        if (e_cnt == int'(gr_c_i) && !bc) em |= 4;
        if (e_cnt == int'(gr_d_i) && !bd) em |= 8;
        check((bc || bd) ? "R8 buffered match" : "R4 match flags", int'(match_o), em);
        check("R9 clear pulse", int'(clr_out_o), int'(m >= 0 && e_cnt == m));
      end
    end
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    clr_sel_i = 3'd1;
    @(negedge clk_i);
    check("R1 cnt in reset", int'(cnt_o), 0);
    check("R1 clr_out in reset", int'(clr_out_o), 0);
    rst_ni = 1'b1;
    check("R1 cnt after reset", int'(cnt_o), 0);

    // R2 internal division sweep
    clr_sel_i = 3'd0;
    for (int s = 0; s < 4; s++) begin
      clk_sel_i = 3'(s);
      do_reset();
      for (int e = 1; e <= 160; e++) begin
        @(negedge clk_i);
        check("R2 divided count", int'(cnt_o), e / (1 << (2 * s)));
      end
    end

    // R4 R5 R6 R9 R10 clear codes, then R8 with buffers on
    sweep_clear(1'b0, 1'b0);
    sweep_clear(1'b1, 1'b1);

    // R3 external pins, other pins toggled fast
    clr_sel_i = 3'd0;
    for (int k = 0; k < 4; k++) begin
      clk_sel_i = 3'(4 + k);
      ext_clk_i = '0;
      do_reset();
      for (int p = 0; p < 5; p++) begin
        for (int h = 0; h < 8; h++) begin
          ext_clk_i = ~ext_clk_i;
          ext_clk_i[k] = (h < 4);
          @(negedge clk_i);
        end
      end
      ext_clk_i = '0;
      repeat (4) @(negedge clk_i);
      check("R3 external edge count", int'(cnt_o), 5);
    end

    // R7 synchronous clear, codes 011 and 111
    clk_sel_i = 3'd0;
    for (int v = 0; v < 2; v++) begin
      clr_sel_i = (v == 0) ? 3'b011 : 3'b111;
      sync_en_i = 1'b1;
      do_reset();
      repeat (10) @(negedge clk_i);
      check("R7 pre-clear count", int'(cnt_o), 10);
      sync_clr_i = 1'b1;
      @(negedge clk_i);
      check("R7 sync clear zero", int'(cnt_o), 0);
      check("R9 no pulse on sync clear", int'(clr_out_o), 0);
      sync_clr_i = 1'b0;
      @(negedge clk_i);
      check("R7 resumes", int'(cnt_o), 1);
      sync_en_i = 1'b0;
      do_reset();
      repeat (10) @(negedge clk_i);
      sync_clr_i = 1'b1;
      @(negedge clk_i);
      sync_clr_i = 1'b0;
      check("R7 ignored when disabled", int'(cnt_o), 11);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule